// File: doc/BRIEF.md
# Deferred Fault Token Tracker

This block keeps one poison bit per architectural register so that a load issued speculatively can fault without raising anything at once. When such a load would have faulted, its destination register is marked instead. Every operation that later consumes a marked register passes the mark on to its own destination, so the mark follows the dataflow.

A later check operation names one register. If that register is clean, the check does nothing. If it is marked, the block raises a redirect to a recovery address that the check supplies.

Each cycle the block takes at most one retiring write (an ALU result or a speculative load) and at most one check. The full token vector is exposed as an output. Memory access, exception delivery and the recovery code itself are handled elsewhere.

Top module: `deferred_fault_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every token and deasserts `redirect_valid` at that edge.
- R2: A retiring speculative load (`wr_valid`=1, `wr_is_load`=1) with `ld_fault`=1 sets the token of `wr_dst`; the load's source fields are ignored.
- R3: A retiring speculative load with `ld_fault`=0 clears the token of `wr_dst`.
- R4: A retiring ALU write (`wr_is_load`=0) sets the token of `wr_dst` when any enabled source (`src_a_en`/`src_b_en`) names a marked register; a source whose enable is 0 has no effect even if it names a marked register.
- R5: A retiring ALU write whose enabled sources are all clean clears the token of `wr_dst`.
- R6: A check (`chk_valid`=1) on a clean register gives `redirect_valid`=0 on the next cycle and changes no token.
- R7: A check on a marked register gives `redirect_valid`=1 on the next cycle with `redirect_target` equal to the check's `chk_target`; the token stays set.
- R8: When a check and a write to the same register retire in one cycle, the check sees the token as it was before that write.
- R9: Only the token of `wr_dst` can change on a write; with `wr_valid`=0 the token vector holds its value, and bit i of `tokens` is the token of register i.
- R10: Register specifiers are 7 bits, so registers 0 through 127 are all tracked independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A write-producing operation retires this cycle |
| wr_is_load | input | 1 | 1: speculative load, 0: ALU operation |
| ld_fault | input | 1 | The speculative load would have faulted |
| src_a_en | input | 1 | Source A is used |
| src_a | input | 7 | Source A register |
| src_b_en | input | 1 | Source B is used |
| src_b | input | 7 | Source B register |
| wr_dst | input | 7 | Destination register |
| chk_valid | input | 1 | A check operation retires this cycle |
| chk_reg | input | 7 | Register the check examines |
| chk_target | input | 16 | Recovery address for the check |
| tokens | output | 128 | Current token of every register |
| redirect_valid | output | 1 | Previous cycle's check found a marked register |
| redirect_target | output | 16 | Recovery address of that check |

## Verification
The main stimulus is a chain: a faulting load marks a register, ALU operations carry the mark through one or two sources, with a disabled source naming a marked register to show enables matter, and clean loads and clean ALU writes remove marks again. Checks on clean and marked registers separate the no-op case from the redirect case and confirm the target is the one supplied. A check paired with a clearing write to the same register in one cycle distinguishes read-before-write from read-after-write. Registers 0 and 127 show the whole 7-bit range is live, and a whole-vector comparison around one write shows no other token moves.

// File: rtl/deferred_fault_tracker.sv
module deferred_fault_tracker #(
  parameter int REG_W = 7,
  parameter int TGT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic                  wr_is_load,
  input  logic                  ld_fault,
  input  logic                  src_a_en,
  input  logic [REG_W-1:0]      src_a,
  input  logic                  src_b_en,
  input  logic [REG_W-1:0]      src_b,
  input  logic [REG_W-1:0]      wr_dst,
  input  logic                  chk_valid,
  input  logic [REG_W-1:0]      chk_reg,
  input  logic [TGT_W-1:0]      chk_target,
  output logic [(1<<REG_W)-1:0] tokens,
  output logic                  redirect_valid,
  output logic [TGT_W-1:0]      redirect_target
);
  localparam int NREGS = 1 << REG_W;

  logic [NREGS-1:0] tok_q;
  logic             src_hit, new_tok, chk_hit;

  assign src_hit = (src_a_en & tok_q[src_a]) | (src_b_en & tok_q[src_b]);
  assign new_tok = wr_is_load ? ld_fault : src_hit;
  assign chk_hit = chk_valid & tok_q[chk_reg];
  assign tokens  = tok_q;

  always_ff @(posedge clk) begin
    if (rst)
      tok_q <= '0;
    else if (wr_valid)
      tok_q[wr_dst] <= new_tok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
    end else begin
      redirect_valid <= chk_hit;
      if (chk_hit)
        redirect_target <= chk_target;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (tokens == '0 && !redirect_valid));

  p_fault_load_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_is_load && ld_fault) |=> tokens[$past(wr_dst)]);

  p_clean_load_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_is_load && !ld_fault) |=> !tokens[$past(wr_dst)]);

  p_alu_propagates_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_is_load && src_a_en && tokens[src_a]) |=> tokens[$past(wr_dst)]);

  p_alu_clean_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_is_load && !(src_a_en && tokens[src_a]) && !(src_b_en && tokens[src_b]))
      |=> !tokens[$past(wr_dst)]);

  p_check_clean_noop_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !tokens[chk_reg] && !wr_valid) |=> (!redirect_valid && $stable(tokens)));

  p_check_marked_redirects_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && tokens[chk_reg]) |=> (redirect_valid && redirect_target == $past(chk_target)));

  p_no_check_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !redirect_valid);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(tokens));

  p_one_bit_moves_r9: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> $countones(tokens ^ $past(tokens)) <= 1);
endmodule

// File: tb/deferred_fault_tracker_test.sv
module deferred_fault_tracker_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_valid, wr_is_load, ld_fault, src_a_en, src_b_en, chk_valid;
  logic [6:0]   src_a, src_b, wr_dst, chk_reg;
  logic [15:0]  chk_target;
  logic [127:0] tokens;
  logic         redirect_valid;
  logic [15:0]  redirect_target;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  deferred_fault_tracker uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_is_load(wr_is_load),
    .ld_fault(ld_fault), .src_a_en(src_a_en), .src_a(src_a),
    .src_b_en(src_b_en), .src_b(src_b), .wr_dst(wr_dst),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_target(chk_target),
    .tokens(tokens), .redirect_valid(redirect_valid),
    .redirect_target(redirect_target)
  );

  typedef struct packed {
    logic       wv, ld, flt, ae;
    logic [6:0] a;
    logic       be;
    logic [6:0] b;
    logic [6:0] d;
    logic       cv;
    logic [6:0] c;
    logic [7:0] tgt;
    logic [6:0] probe;
    logic       ptok;
    logic       red;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1,1,1,0,7'd0,  0,7'd0,  7'd5,  0,7'd0,  8'h00, 7'd5,  1,0}, // R2
    '{1,1,0,0,7'd0,  0,7'd0,  7'd6,  0,7'd0,  8'h00, 7'd6,  0,0}, // R3
    '{1,0,0,1,7'd5,  0,7'd0,  7'd7,  0,7'd0,  8'h00, 7'd7,  1,0}, // R4
    '{1,0,0,1,7'd6,  1,7'd7,  7'd8,  0,7'd0,  8'h00, 7'd8,  1,0}, // R4 via B
    '{1,0,0,1,7'd6,  0,7'd5,  7'd9,  0,7'd0,  8'h00, 7'd9,  0,0}, // R4 disabled src
    '{0,0,0,0,7'd0,  0,7'd0,  7'd0,  1,7'd6,  8'h11, 7'd6,  0,0}, // R6
    '{0,0,0,0,7'd0,  0,7'd0,  7'd0,  1,7'd8,  8'h22, 7'd8,  1,1}, // R7
    '{1,1,0,0,7'd0,  0,7'd0,  7'd5,  1,7'd5,  8'h33, 7'd5,  0,1}, // R8
    '{0,0,0,0,7'd0,  0,7'd0,  7'd0,  1,7'd5,  8'h44, 7'd5,  0,0}, // R6 after clear
    '{1,0,0,1,7'd6,  1,7'd9,  7'd7,  0,7'd0,  8'h00, 7'd7,  0,0}, // R5
    '{1,1,1,0,7'd0,  0,7'd0,  7'd127,1,7'd0,  8'h55, 7'd127,1,0}, // R10
    '{1,0,0,1,7'd127,0,7'd0,  7'd0,  1,7'd127,8'h66, 7'd0,  1,1}, // R10
    '{0,0,0,0,7'd0,  0,7'd0,  7'd0,  0,7'd0,  8'h00, 7'd127,1,0}  // R9
  };

  task automatic idle_inputs();
    wr_valid = 0; wr_is_load = 0; ld_fault = 0; src_a_en = 0; src_a = '0;
    src_b_en = 0; src_b = '0; wr_dst = '0; chk_valid = 0; chk_reg = '0;
    chk_target = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] snap;
    idle_inputs();
    rst = 1;
    @(negedge clk);
    step();
    rst = 0;
    check(tokens == '0, "R1", "tokens after reset", tokens, '0);
    check(!redirect_valid, "R1", "redirect after reset", redirect_valid, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_valid = TBL[i].wv; wr_is_load = TBL[i].ld; ld_fault = TBL[i].flt;
      src_a_en = TBL[i].ae; src_a = TBL[i].a; src_b_en = TBL[i].be;
      src_b = TBL[i].b; wr_dst = TBL[i].d; chk_valid = TBL[i].cv;
      chk_reg = TBL[i].c; chk_target = {8'h00, TBL[i].tgt};
      step();
      check(tokens[TBL[i].probe] == TBL[i].ptok, "R2-R10 table", $sformatf("token row %0d", i),
            tokens[TBL[i].probe], TBL[i].ptok);
      check(redirect_valid == TBL[i].red, "R6/R7 table", $sformatf("redirect row %0d", i),
            redirect_valid, TBL[i].red);
      if (TBL[i].red)
        check(redirect_target == {8'h00, TBL[i].tgt}, "R7", $sformatf("target row %0d", i),
              redirect_target, {8'h00, TBL[i].tgt});
    end

    // R9: a write changes only its destination bit
    @(negedge clk);
    idle_inputs();
    snap = tokens;
    wr_valid = 1; wr_is_load = 1; ld_fault = 1; wr_dst = 7'd1;
    step();
    check(tokens == (snap | (128'd1 << 1)), "R9", "only dst bit changes", tokens,
          snap | (128'd1 << 1));

    // R2: load source fields ignored even if they name a clean register
    @(negedge clk);
    idle_inputs();
    wr_valid = 1; wr_is_load = 1; ld_fault = 1; src_a_en = 1; src_a = 7'd6; wr_dst = 7'd2;
    step();
    check(tokens[2] == 1'b1, "R2", "faulting load with clean source", tokens[2], 1);

    // R6: check on clean register leaves token vector unchanged
    @(negedge clk);
    idle_inputs();
    snap = tokens;
    chk_valid = 1; chk_reg = 7'd3; chk_target = 16'hBEEF;
    step();
    check(tokens == snap && !redirect_valid, "R6", "clean check no-op",
          {tokens[126:0], redirect_valid}, {snap[126:0], 1'b0});

    // R1: reset mid-activity, while a marked check and faulting load arrive
    @(negedge clk);
    idle_inputs();
    rst = 1; wr_valid = 1; wr_is_load = 1; ld_fault = 1; wr_dst = 7'd4;
    chk_valid = 1; chk_reg = 7'd127; chk_target = 16'h1234;
    step();
    check(tokens == '0, "R1", "tokens after mid-run reset", tokens, '0);
    check(!redirect_valid, "R1", "redirect after mid-run reset", redirect_valid, 0);
    @(negedge clk);
    rst = 0;
    idle_inputs();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule